// File: doc/BRIEF.md
# CAN Transceiver Operating Mode Controller

This block holds the digital mode logic of a CAN bus transceiver that has a low-power standby state. A host pin chooses between normal operation and standby. Two supply-health flags act on top of that pin. One flag reports that the main supply is too low for normal operation. The other reports that a supply is too low to run at all. A wake-detected flag comes from a separate low-power bus monitor. From these inputs the block decides four things: which transceiver paths are powered, whether the bus lines are pulled toward ground, whether the node stays off the bus, and which source drives the receive-data pin.

The block has four internal states: off, standby, arming and normal. Arming is the power-up interval between standby and normal. The receive path is already on during arming, but the transmitter stays disabled until a parameterised number of clock cycles has passed. Both undervoltage flags override the host pin. In standby the receive pin stays high until a wake event has been latched, and after that it follows the low-power receiver. The wake latch is cleared whenever the block leaves standby.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: After a synchronous active-low reset the block is off: bus_release=1, tx_en=0, nrx_en=0, bias_gnd=0, rxd=1, rxd_sel=2'b00. It stays off while either uv_stb or uv_off is 1.
- R2: When the block is off and uv_off and uv_stb are both 0 at a clock edge, the block is in standby after that edge, whatever the value of stb_sel.
- R3: If uv_off is 1 at a clock edge, the block is off after that edge, whatever state it was in and whatever the other inputs are.
- R4: In standby: bias_gnd=1, tx_en=0, nrx_en=0, bus_release=0.
- R5: In standby with no wake latched, rxd=1 and rxd_sel=2'b00, whatever lp_rx is.
- R6: If wake_det is 1 at a clock edge during standby, and standby continues, then from the next cycle rxd equals lp_rx and rxd_sel=2'b10 for as long as standby lasts.
- R7: If stb_sel=0 and uv_stb=0 at an edge during standby, the block enters arming. Arming gives nrx_en=1, bias_gnd=0, tx_en=0, rxd_sel=2'b01. After exactly DELAY_CYC cycles of arming, tx_en becomes 1 (normal state).
- R8: If stb_sel=1 at an edge during arming or normal, the block is in standby after that edge.
- R9: If uv_stb=1 at an edge during arming or normal, the block goes to standby. While uv_stb stays 1, standby is held even with stb_sel=0.
- R10: In normal: tx_en=1, nrx_en=1, bias_gnd=0, bus_release=0, rxd_sel=2'b01, and rxd equals nr_rx (0 for dominant, 1 for recessive), whatever lp_rx is.
- R11: Leaving standby clears the wake latch. A wake_det seen outside standby is ignored. The next standby period therefore starts with rxd=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stb_sel | input | 1 | Host mode select: 1 = standby, 0 = normal |
| uv_stb | input | 1 | Main supply is below its standby threshold |
| uv_off | input | 1 | A supply is below its switch-off threshold |
| wake_det | input | 1 | Valid bus wake pattern seen by the low-power monitor |
| lp_rx | input | 1 | Bus level from the low-power receiver (0 = dominant) |
| nr_rx | input | 1 | Bus level from the normal receiver (0 = dominant) |
| tx_en | output | 1 | Transmitter enable |
| nrx_en | output | 1 | Normal receiver enable |
| bias_gnd | output | 1 | Pull the bus lines toward ground |
| bus_release | output | 1 | Present zero load to the bus |
| rxd_sel | output | 2 | Receive-pin source: 00 forced high, 01 normal receiver, 10 low-power receiver |
| rxd | output | 1 | Receive data to the protocol controller |

## Verification
The bench runs an exhaustive sweep. It applies every combination of the four control inputs from the off, standby and normal states, and it compares the resulting enable pattern with the pattern the requirements predict. A design with the wrong priority order between the two supply flags and the host pin shows up here: it would, for example, enter arming while uv_stb is set, or leave the off state too early. The bench also counts arming cycles one by one. A counter that is off by one would turn on the transmitter a cycle early or late. The wake tests cover two cases. A design that does not clear the wake latch when it leaves standby would let bus activity reach rxd at the start of the next standby period. A design that accepts wake_det outside standby would do the same.

// File: rtl/xcvr_mode_pkg.sv
// Shared types for the transceiver mode controller.
// Assumes: two-bit encodings are used by every submodule and by the ports.
package xcvr_mode_pkg;

    // Operating states of the controller
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_STBY = 2'd1,
        ST_ARM  = 2'd2,
        ST_NORM = 2'd3
    } xmode_e;

    // Source selection for the receive-data pin
    typedef enum logic [1:0] {
        RXS_HIGH = 2'b00,
        RXS_NORM = 2'b01,
        RXS_LP   = 2'b10
    } rxsel_e;

endpackage

// File: rtl/xcvr_mode_fsm.sv
// Mode state machine: off / standby / arming / normal.
// The supply flags take priority over the host select pin. The arming interval
// lasts DELAY_CYC cycles before normal is entered.
// Assumes: DELAY_CYC >= 1 and the inputs are already synchronous to clk.
module xcvr_mode_fsm
    import xcvr_mode_pkg::*;
#(
    parameter int DELAY_CYC = 5875
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   stb_sel,
    input  logic   uv_stb,
    input  logic   uv_off,
    output xmode_e state,
    output xmode_e state_nx
);
    localparam int CW = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DELAY_CYC - 1);

    logic [CW-1:0] cnt;
    logic          arm_done;

    assign arm_done = (cnt == CNT_LAST);

    // Next-state decision; switch-off has the highest priority
    always_comb begin
        state_nx = state;
        if (uv_off) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:  if (!uv_stb) state_nx = ST_STBY;
                ST_STBY: if (!stb_sel && !uv_stb) state_nx = ST_ARM;
                ST_ARM: begin
                    if (stb_sel || uv_stb) state_nx = ST_STBY;
                    else if (arm_done)     state_nx = ST_NORM;
                end
                ST_NORM: if (stb_sel || uv_stb) state_nx = ST_STBY;
                default: state_nx = ST_OFF;
            endcase
        end
    end

    // State register; reset lands in off
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // Arming cycle counter; cleared outside arming
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (state_nx != ST_ARM) cnt <= '0;
        else if (state == ST_ARM)    cnt <= cnt + 1'b1;
        else                         cnt <= '0;
    end

    AST_OFF_ON_SWOFF: assert property (@(posedge clk) disable iff (!rst_n)
        uv_off |=> (state == ST_OFF)); // R3

    AST_NORM_FROM_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORM) |-> ($past(state) == ST_ARM || $past(state) == ST_NORM)); // R7

    AST_UVSTB_BLOCKS_NORM: assert property (@(posedge clk) disable iff (!rst_n)
        uv_stb |=> (state != ST_NORM && state != ST_ARM)); // R9

    AST_OFF_EXIT_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_OFF) && (uv_off || uv_stb)) |=> (state == ST_OFF)); // R1

endmodule

// File: rtl/xcvr_wake_latch.sv
// Holds the wake-seen flag for the current standby period.
// Set by wake_det only while in standby; cleared when the next state is anything
// other than standby.
// Assumes: wake_det is a level or pulse synchronous to clk.
module xcvr_wake_latch
    import xcvr_mode_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  xmode_e state,
    input  xmode_e state_nx,
    input  logic   wake_det,
    output logic   wake_q
);
    logic stay_stby;

    assign stay_stby = (state_nx == ST_STBY);

    // Latch a wake event during standby; drop it on leaving standby
    always_ff @(posedge clk) begin
        if (!rst_n)          wake_q <= 1'b0;
        else if (!stay_stby) wake_q <= 1'b0;
        else if ((state == ST_STBY) && wake_det) wake_q <= 1'b1;
    end

    AST_WAKE_ONLY_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> (state == ST_STBY)); // R11

    AST_WAKE_NEEDS_STBY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_q) |-> ($past(state) == ST_STBY && $past(wake_det))); // R6

endmodule

// File: rtl/xcvr_out_decode.sv
// Turns the mode state into path enables and bus controls, and selects the
// source of the receive-data pin.
// Assumes: lp_rx and nr_rx are 0 for a dominant bus and 1 for a recessive bus.
module xcvr_out_decode
    import xcvr_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  xmode_e     state,
    input  logic       wake_q,
    input  logic       lp_rx,
    input  logic       nr_rx,
    output logic       tx_en,
    output logic       nrx_en,
    output logic       bias_gnd,
    output logic       bus_release,
    output logic [1:0] rxd_sel,
    output logic       rxd
);
    rxsel_e sel;

    // Per-state enables and receive source
    always_comb begin
        tx_en       = 1'b0;
        nrx_en      = 1'b0;
        bias_gnd    = 1'b0;
        bus_release = 1'b0;
        sel         = RXS_HIGH;
        unique case (state)
            ST_OFF:  bus_release = 1'b1;
            ST_STBY: begin
                bias_gnd = 1'b1;
                sel      = wake_q ? RXS_LP : RXS_HIGH;
            end
            ST_ARM: begin
                nrx_en = 1'b1;
                sel    = RXS_NORM;
            end
            ST_NORM: begin
                tx_en  = 1'b1;
                nrx_en = 1'b1;
                sel    = RXS_NORM;
            end
            default: bus_release = 1'b1;
        endcase
    end

    // Receive-pin multiplexer
    always_comb begin
        unique case (sel)
            RXS_NORM: rxd = nr_rx;
            RXS_LP:   rxd = lp_rx;
            default:  rxd = 1'b1;
        endcase
    end

    assign rxd_sel = sel;

    AST_TX_NOT_BIASED: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en && bias_gnd)); // R4

    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_release |-> (!tx_en && !nrx_en && !bias_gnd && rxd)); // R1

    AST_STBY_RXD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bias_gnd && !wake_q) |-> rxd); // R5

    AST_TX_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> (nrx_en && rxd == nr_rx)); // R10

endmodule

// File: rtl/xcvr_mode_ctrl.sv
// Top of the transceiver mode controller: wires the state machine, the wake
// latch and the output decoder together.
// Assumes: all inputs are synchronous to clk; DELAY_CYC is the standby-to-normal
// delay counted in clock cycles.
module xcvr_mode_ctrl
    import xcvr_mode_pkg::*;
#(
    parameter int DELAY_CYC = 5875
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb_sel,
    input  logic       uv_stb,
    input  logic       uv_off,
    input  logic       wake_det,
    input  logic       lp_rx,
    input  logic       nr_rx,
    output logic       tx_en,
    output logic       nrx_en,
    output logic       bias_gnd,
    output logic       bus_release,
    output logic [1:0] rxd_sel,
    output logic       rxd
);
    xmode_e state;
    xmode_e state_nx;
    logic   wake_q;

    xcvr_mode_fsm #(.DELAY_CYC(DELAY_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_sel  (stb_sel),
        .uv_stb   (uv_stb),
        .uv_off   (uv_off),
        .state    (state),
        .state_nx (state_nx)
    );

    xcvr_wake_latch u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .state_nx (state_nx),
        .wake_det (wake_det),
        .wake_q   (wake_q)
    );

    xcvr_out_decode u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .wake_q      (wake_q),
        .lp_rx       (lp_rx),
        .nr_rx       (nr_rx),
        .tx_en       (tx_en),
        .nrx_en      (nrx_en),
        .bias_gnd    (bias_gnd),
        .bus_release (bus_release),
        .rxd_sel     (rxd_sel),
        .rxd         (rxd)
    );

endmodule

// File: tb/xcvr_mode_ctrl_tb.sv
module xcvr_mode_ctrl_tb;
    localparam int DLY = 4;

    logic clk = 1'b0;
    logic rst_n, stb_sel, uv_stb, uv_off, wake_det, lp_rx, nr_rx;
    logic tx_en, nrx_en, bias_gnd, bus_release, rxd;
    logic [1:0] rxd_sel;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Output patterns {tx_en, nrx_en, bias_gnd, bus_release}
    localparam logic [3:0] P_OFF  = 4'b0001;
    localparam logic [3:0] P_STBY = 4'b0010;
    localparam logic [3:0] P_ARM  = 4'b0100;
    localparam logic [3:0] P_NORM = 4'b1100;

    always #4 clk = ~clk;

    xcvr_mode_ctrl #(.DELAY_CYC(DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .stb_sel(stb_sel), .uv_stb(uv_stb),
        .uv_off(uv_off), .wake_det(wake_det), .lp_rx(lp_rx), .nr_rx(nr_rx),
        .tx_en(tx_en), .nrx_en(nrx_en), .bias_gnd(bias_gnd),
        .bus_release(bus_release), .rxd_sel(rxd_sel), .rxd(rxd)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat();
        return {4'b0, tx_en, nrx_en, bias_gnd, bus_release};
    endfunction

    task automatic to_off();
        uv_off = 1'b1; tick(); uv_off = 1'b0;
    endtask

    task automatic to_stby();
        stb_sel = 1'b1; uv_stb = 1'b0; wake_det = 1'b0;
        to_off(); tick();
    endtask

    task automatic to_norm();
        to_stby(); stb_sel = 1'b0;
        for (int i = 0; i <= DLY; i++) tick();
    endtask

    initial begin
        rst_n = 1'b0; stb_sel = 1'b1; uv_stb = 1'b1; uv_off = 1'b1;
        wake_det = 1'b0; lp_rx = 1'b1; nr_rx = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1; stb_sel = 1'b0;
        tick();
        chk("R1 reset", {pat()[3:0], rxd_sel, rxd, 1'b0}, {P_OFF, 2'b00, 1'b1, 1'b0});
        uv_off = 1'b0; tick();
        chk("R1 uv_stb holds off", pat(), {4'b0, P_OFF});
        uv_stb = 1'b0; tick();
        chk("R2 off to standby", pat(), {4'b0, P_STBY});

        // Exhaustive one-step sweep from off, standby, normal
        for (int s = 0; s < 3; s++) begin
            for (int v = 0; v < 16; v++) begin
                logic [3:0] exp;
                logic sb, us, uo;
                if (s == 0) to_off(); else if (s == 1) to_stby(); else to_norm();
                sb = v[0]; us = v[1]; uo = v[2];
                stb_sel = sb; uv_stb = us; uv_off = uo; wake_det = v[3];
                tick();
                if (uo) exp = P_OFF;
                else if (s == 0) exp = us ? P_OFF : P_STBY;
                else if (s == 1) exp = (!sb && !us) ? P_ARM : P_STBY;
                else exp = (sb || us) ? P_STBY : P_NORM;
                chk(uo ? "R3 sweep" : (s == 0 ? "R2 sweep" : (s == 1 ? "R7 sweep" : "R9 sweep")),
                    pat(), {4'b0, exp});
                uv_off = 1'b0; wake_det = 1'b0;
            end
        end

        // Arming length
        to_stby(); stb_sel = 1'b0; tick();
        chk("R7 arming enables", {pat()[3:0], rxd_sel, 2'b0}, {P_ARM, 2'b01, 2'b0});
        for (int i = 1; i < DLY; i++) begin
            tick();
            chk("R7 tx held during arming", pat(), {4'b0, P_ARM});
        end
        tick();
        chk("R7 tx on after delay", pat(), {4'b0, P_NORM});

        // Normal receive path
        for (int k = 0; k < 4; k++) begin
            nr_rx = k[0]; lp_rx = k[1]; #1;
            chk("R10 rxd follows normal rx", {5'b0, rxd_sel, rxd}, {5'b0, 2'b01, k[0]});
        end

        // Arming abort by pin
        to_stby(); stb_sel = 1'b0; tick(); stb_sel = 1'b1; tick();
        chk("R8 arming abort", pat(), {4'b0, P_STBY});
        to_norm(); stb_sel = 1'b1; tick();
        chk("R8 normal to standby", pat(), {4'b0, P_STBY});

        // uv_stb hold
        to_norm(); uv_stb = 1'b1; tick();
        for (int i = 0; i < 3; i++) begin
            stb_sel = 1'b0; tick();
            chk("R9 uv_stb holds standby", pat(), {4'b0, P_STBY});
        end
        uv_stb = 1'b0; tick();
        chk("R9 release to arming", pat(), {4'b0, P_ARM});

        // Wake behaviour
        to_stby();
        for (int k = 0; k < 2; k++) begin
            lp_rx = k[0]; #1;
            chk("R5 rxd high before wake", {5'b0, rxd_sel, rxd}, {5'b0, 2'b00, 1'b1});
        end
        wake_det = 1'b1; tick(); wake_det = 1'b0;
        for (int k = 0; k < 2; k++) begin
            lp_rx = k[0]; #1;
            chk("R6 rxd follows lp rx", {5'b0, rxd_sel, rxd}, {5'b0, 2'b10, k[0]});
        end
        tick(); lp_rx = 1'b0; #1;
        chk("R6 wake persists", {7'b0, rxd}, 8'd0);
        stb_sel = 1'b0; tick(); stb_sel = 1'b1; tick(); lp_rx = 1'b0; #1;
        chk("R11 latch cleared after leaving standby", {5'b0, rxd_sel, rxd}, {5'b0, 2'b00, 1'b1});
        to_norm(); wake_det = 1'b1; tick(); wake_det = 1'b0; stb_sel = 1'b1; tick(); lp_rx = 1'b0; #1;
        chk("R11 wake outside standby ignored", {5'b0, rxd_sel, rxd}, {5'b0, 2'b00, 1'b1});
        to_stby(); wake_det = 1'b1; tick(); wake_det = 1'b0; to_off(); tick(); lp_rx = 1'b0; #1;
        chk("R11 latch cleared by switch-off", {pat()[3:0], rxd_sel, rxd, 1'b0}, {P_STBY, 2'b00, 1'b1, 1'b0});
        chk("R4 standby outputs", pat(), {4'b0, P_STBY});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule